// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block gathers 32 level-sensitive, active-high interrupt sources into four outputs: two ordinary interrupt lines, one per CPU, and two machine-check lines, also one per CPU. Each source input passes through a two-flop synchroniser. The synchronised word forms the status register, which tracks the live level of every source and is never latched. A source therefore clears as soon as its device drops the request, and no acknowledge or end-of-interrupt step exists.

Every output has its own 32-bit enable mask. An output is raised when any bit of the status word ANDed with that output's mask is set. The four outputs are evaluated independently, so a source enabled in several masks raises all of those outputs at the same time.

Software works through a single-cycle register port. It can read the raw status, read and write the four masks, and read a vector register. The vector register names the highest-numbered enabled pending source for CPU 0.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all four masks read zero, all four outputs are low, and `rdata` is zero.
- R2: Reading offset 0x00 returns the source levels synchronised by two flops. A source input change is visible at the status register on the second rising edge after it occurs. A source that drops clears its status bit with no acknowledge.
- R3: The masks are read/write 32-bit registers. The CPU 0 interrupt mask is at 0x10, the CPU 1 interrupt mask at 0x14, the CPU 0 machine-check mask at 0x18 and the CPU 1 machine-check mask at 0x1C. A mask changes only when its own offset is written.
- R4: Each output is registered. It is high one cycle after (status AND its mask) is non-zero, and low one cycle after that AND becomes zero. `cpu_irq_o[n]` follows the interrupt mask of CPU n, and `mcheck_o[n]` follows the machine-check mask of CPU n.
- R5: The outputs are independent. One source enabled in several masks raises every matching output at once.
- R6: Offset 0x20 is read-only. When (status AND CPU 0 interrupt mask) is non-zero, bit 31 is 1 and bits 4:0 hold the highest set bit index of that AND. When the AND is zero, the register reads all zero.
- R7: Writes to 0x00, 0x20 and any offset not listed in R3 are ignored. Reads of offsets other than 0x00, 0x10, 0x14, 0x18, 0x1C and 0x20 return zero. Only exact byte offsets decode.
- R8: Read data appears on `rdata` on the cycle after `rd_en` is sampled high. The value then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 32 | Level-sensitive interrupt source inputs, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, valid the cycle after `rd_en` |
| cpu_irq_o | output | 2 | Interrupt lines to CPU 0 and CPU 1 |
| mcheck_o | output | 2 | Machine-check lines to CPU 0 and CPU 1 |

## Verification
The hardest situation to reach from the ports is a source that is pending, enabled in some masks and blocked in others, while lower-numbered enabled sources are also pending. This is the case that separates a correct highest-index search and independent output routing from near misses. The stimulus reaches it with a long pseudo-random sweep that loads all four masks and the source word with unrelated values. This is backed by walking-one sweeps over every source bit against full and single-bit masks. Each case is checked against status, outputs and vector values that the bench computes arithmetically.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NUM_TGT = 4;

  localparam logic [ADDR_W-1:0] OFF_STATUS    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_VECTOR    = 8'h20;

  typedef enum logic [1:0] {
    TGT_CPU0 = 2'd0,
    TGT_CPU1 = 2'd1,
    TGT_MC0  = 2'd2,
    TGT_MC1  = 2'd3
  } tgt_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC = 32,
  parameter int NUM_TGT = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              status,
  input  logic [NUM_TGT-1:0]              mask_we,
  input  logic [NUM_SRC-1:0]              mask_wdata,
  output logic [NUM_TGT-1:0][NUM_SRC-1:0] mask_q,
  output logic [NUM_TGT-1:0]              out_q
);
  logic [NUM_TGT-1:0][NUM_SRC-1:0] mask_d;
  logic [NUM_TGT-1:0]              out_d;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    always_comb begin
      mask_d[t] = mask_q[t];
      if (mask_we[t]) mask_d[t] = mask_wdata;
      out_d[t] = |(status & mask_q[t]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[t] <= '0;
        out_q[t]  <= 1'b0;
      end else begin
        if (mask_we[t]) mask_q[t] <= mask_d[t];
        out_q[t] <= out_d[t];
      end
    end

    // R3: a mask changes only through its own write strobe
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we[t] |=> $stable(mask_q[t]));

    // R4: no enabled pending source leaves the output low a cycle later
    assert_out_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & mask_q[t]) == '0) |=> !out_q[t]);

    // R5: any enabled pending source raises this output regardless of others
    assert_out_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & mask_q[t]) != '0) |=> out_q[t]);
  end
endmodule

// File: rtl/irq_vector.sv
module irq_vector #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] active,
  output logic               valid,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [1:0]         cpu_irq_o,
  output logic [1:0]         mcheck_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_sync_n;
  irq_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  // source synchroniser; its last stage is the status register
  logic [NUM_SRC-1:0] status;
  irq_sync #(.WIDTH(NUM_SRC), .STAGES(2)) u_src_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(src_i), .q(status)
  );

  // write decode
  logic [NUM_TGT-1:0] mask_we;
  always_comb begin
    for (int t = 0; t < NUM_TGT; t++) begin
      mask_we[t] = wr_en && (addr == OFF_MASK_BASE + ADDR_W'(4 * t));
    end
  end

  logic [NUM_TGT-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_TGT-1:0]              out_q;
  irq_route #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT)) u_route (
    .clk(clk), .rst_n(rst_sync_n), .status(status), .mask_we(mask_we),
    .mask_wdata(wdata[NUM_SRC-1:0]), .mask_q(mask_q), .out_q(out_q)
  );

  assign cpu_irq_o = {out_q[TGT_CPU1], out_q[TGT_CPU0]};
  assign mcheck_o  = {out_q[TGT_MC1],  out_q[TGT_MC0]};

  // vector for CPU 0
  logic [NUM_SRC-1:0] active0;
  logic               vec_valid;
  logic [IDX_W-1:0]   vec_idx;
  assign active0 = status & mask_q[TGT_CPU0];
  irq_vector #(.NUM_SRC(NUM_SRC)) u_vector (
    .active(active0), .valid(vec_valid), .idx(vec_idx)
  );

  logic [DATA_W-1:0] vec_word;
  always_comb begin
    vec_word               = '0;
    vec_word[DATA_W-1]     = vec_valid;
    vec_word[IDX_W-1:0]    = vec_valid ? vec_idx : '0;
  end

  // read mux and read data register
  logic [DATA_W-1:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (addr == OFF_STATUS) rdata_d = DATA_W'(status);
    if (addr == OFF_VECTOR) rdata_d = vec_word;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (addr == OFF_MASK_BASE + ADDR_W'(4 * t)) rdata_d = DATA_W'(mask_q[t]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata <= '0;
    else if (rd_en)   rdata <= rdata_d;
  end

  // R8: read data holds between reads
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rdata));

  // R6: a valid vector points at a pending enabled source
  assert_vec_hit_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid |-> active0[vec_idx]);

  // R6: nothing above the reported index is pending and enabled
  assert_vec_top_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid |-> ((active0 >> vec_idx) == NUM_SRC'(1)));

  // R6: no valid flag means nothing enabled is pending
  assert_vec_empty_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vec_valid |-> (active0 == '0));

  // R7: only exact mask offsets can produce a write strobe
  assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (addr == OFF_STATUS || addr == OFF_VECTOR)) |-> (mask_we == '0));
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_i;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  cpu_irq_o, mcheck_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .cpu_irq_o(cpu_irq_o), .mcheck_o(mcheck_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] vec_of(logic [31:0] act);
    for (int i = 31; i >= 0; i--) begin
      if (act[i]) return 32'h8000_0000 | 32'(i);
    end
    return 32'h0;
  endfunction

  localparam logic [7:0] MASK_OFF [4] = '{8'h10, 8'h14, 8'h18, 8'h1C};

  task automatic check_all(string tag, logic [31:0] s, logic [31:0] m [4]);
    logic [31:0] r;
    logic [3:0]  o;
    for (int t = 0; t < 4; t++) o[t] = |(s & m[t]);
    check({tag, " R4 cpu_irq"}, 32'(cpu_irq_o), 32'(o[1:0]));
    check({tag, " R5 mcheck"},  32'(mcheck_o),  32'(o[3:2]));
    reg_read(8'h00, r); check({tag, " R2 status"}, r, s);
    reg_read(8'h20, r); check({tag, " R6 vector"}, r, vec_of(s & m[0]));
  endtask

  initial begin
    logic [31:0] r, lcg;
    logic [31:0] m [4];
    rst_n = 1'b0; src_i = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    settle(5);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    check("R1 cpu_irq reset", 32'(cpu_irq_o), 32'h0);
    check("R1 mcheck reset",  32'(mcheck_o),  32'h0);
    check("R1 rdata reset",   rdata, 32'h0);
    for (int t = 0; t < 4; t++) begin
      reg_read(MASK_OFF[t], r); check("R1 mask reset", r, 32'h0);
    end

    // R3 walking-one on every mask bit
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 32; b++) begin
        reg_write(MASK_OFF[t], 32'h1 << b);
        reg_read(MASK_OFF[t], r); check("R3 mask walk", r, 32'h1 << b);
      end
    end
    for (int t = 0; t < 4; t++) m[t] = 32'hA5A5_0000 ^ (32'h1111_1111 * (t + 1));
    for (int t = 0; t < 4; t++) reg_write(MASK_OFF[t], m[t]);
    for (int t = 0; t < 4; t++) begin
      reg_read(MASK_OFF[t], r); check("R3 mask distinct", r, m[t]);
    end

    // R7 ignored writes and unmapped reads
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_write(8'h20, 32'hFFFF_FFFF);
    reg_write(8'h04, 32'hFFFF_FFFF);
    reg_write(8'h11, 32'hFFFF_FFFF);
    reg_write(8'h24, 32'hFFFF_FFFF);
    reg_write(8'h90, 32'hFFFF_FFFF);
    for (int t = 0; t < 4; t++) begin
      reg_read(MASK_OFF[t], r); check("R7 mask untouched", r, m[t]);
    end
    reg_read(8'h00, r); check("R7 status untouched", r, 32'h0);
    reg_read(8'h20, r); check("R7 vector untouched", r, 32'h0);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] ua;
      ua = (k == 0) ? 8'h04 : (k == 1) ? 8'h12 : (k == 2) ? 8'h24 :
           (k == 3) ? 8'h0C : (k == 4) ? 8'h1F : 8'hFF;
      reg_read(ua, r); check("R7 unmapped read", r, 32'h0);
    end

    // R2/R4 timing: source rises, status at edge 2, output at edge 3
    for (int t = 0; t < 4; t++) begin m[t] = 32'h0000_0100; reg_write(MASK_OFF[t], m[t]); end
    @(negedge clk); src_i = 32'h0000_0100;
    settle(2);
    check("R4 output not before 3rd edge", 32'({mcheck_o, cpu_irq_o}), 32'h0);
    settle(1);
    check("R4 output at 3rd edge", 32'({mcheck_o, cpu_irq_o}), 32'hF);
    // R2 non-latching clear
    src_i = 32'h0;
    settle(4);
    check("R2 cleared outputs", 32'({mcheck_o, cpu_irq_o}), 32'h0);
    reg_read(8'h00, r); check("R2 status cleared", r, 32'h0);

    // R4 mask change reaches output one cycle after the write edge
    src_i = 32'h0000_0001; settle(4);
    @(negedge clk); wr_en = 1'b1; addr = 8'h10; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    check("R4 mask write, output not yet", 32'(cpu_irq_o), 32'h0);
    @(negedge clk);
    check("R4 mask write, output one cycle later", 32'(cpu_irq_o), 32'h1);
    m[0] = 32'h1;

    // R8 rdata holds without rd_en
    reg_read(8'h10, r);
    wr_en = 1'b0; addr = 8'h00; settle(3);
    check("R8 rdata held", rdata, 32'h1);

    // R6 walking source with full mask 0, others cleared
    m[0] = 32'hFFFF_FFFF; m[1] = 32'h0; m[2] = 32'h0; m[3] = 32'h0;
    for (int t = 0; t < 4; t++) reg_write(MASK_OFF[t], m[t]);
    for (int b = 0; b < 32; b++) begin
      @(negedge clk); src_i = 32'h1 << b; settle(4);
      check_all("walk1", src_i, m);
      @(negedge clk); src_i = (32'h1 << b) | ((32'h1 << b) - 1); settle(4);
      check_all("walkfill", src_i, m);
    end

    // R5/R6 pseudo-random sweep with overlapping masks
    lcg = 32'h1234_5678;
    for (int it = 0; it < 300; it++) begin
      for (int t = 0; t < 4; t++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        m[t] = (it % 5 == 0) ? lcg : (lcg & (lcg >> 7));
        reg_write(MASK_OFF[t], m[t]);
      end
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      @(negedge clk); src_i = (it % 3 == 0) ? (lcg & (lcg << 3)) : lcg; settle(4);
      check_all("sweep", src_i, m);
    end

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule